// File: doc/BRIEF.md
# External Bus Read Timing Sequencer

This block runs read cycles on an asynchronous external memory bus that is split into four chip-select banks. An internal requester presents a bank number, an address and a valid flag while the block signals ready. The block then drives the address and the active-low select of that bank, pulls the active-low output enable for a programmed number of clock periods, registers the returned data and reports it with a single-cycle done pulse. Chip select then stays asserted for a programmed turnaround interval.

Every bank keeps its own timing word, written through a small register write port indexed by bank. The word holds an address-setup count, a strobe-width count, a turnaround-hold count and a page enable. With page enable set, the select stays asserted after the strobe and the bank's page stays open. A later read to the same bank and page then costs only a strobe. A read that misses the open page first closes it with the old hold interval and then runs a full cycle. All counts are in system clock periods. A timing word is copied when its read is accepted, so a write only affects reads that start later.

Top module: `ext_rd_seq`

## Requirements
- R1: After reset, req_ready is 1, every bus_cs_n bit and bus_oe_n are 1, rsp_done is 0, and every bank's timing word is setup 15, strobe 63, hold 15 with page mode off.
- R2: After a read is accepted from the closed-page state, the selected bank's bus_cs_n bit and bus_addr are driven for exactly setup cycles with bus_oe_n high before bus_oe_n falls. A setup of 0 makes bus_oe_n low in the first cycle.
- R3: bus_oe_n stays low for exactly strobe cycles. A strobe of 0 gives one cycle.
- R4: rsp_data takes bus_data_in at the clock edge that ends the last strobe cycle. rsp_done is 1 for exactly that one following cycle.
- R5: With page mode off, the bank's select stays low for exactly hold cycles after bus_oe_n rises, with req_ready 0. After that, all selects are high and req_ready returns to 1.
- R6: At most one bus_cs_n bit is ever low. bus_oe_n is low only while exactly one is low and req_ready is 0. Requests are taken only when req_ready is 1.
- R7: Each bank uses only its own timing word. The write port (cfg_we, cfg_bank and the field inputs) replaces the word of bank cfg_bank at the clock edge.
- R8: A timing write has no effect on a read that has already been accepted, including a write at the very edge where that read is accepted. The next read to start uses the new values.
- R9: With page mode on, the select stays low after the strobe with no hold, and req_ready returns to 1 in the cycle right after the strobe.
- R10: A page hit is a request for the open bank whose req_addr matches the open address in all bits above bit 2, while that bank's page mode is still on. A hit skips setup: bus_oe_n falls in the first cycle after acceptance.
- R11: Any other request while a page is open first holds the open bank's select for its hold count with req_ready 0. It then runs a full setup, strobe and hold cycle on the requested bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all counts are in its periods |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Timing write strobe |
| cfg_bank | input | 2 | Bank whose timing word is written |
| cfg_setup | input | 4 | Address setup cycles |
| cfg_strobe | input | 6 | Output-enable cycles (0 acts as 1) |
| cfg_hold | input | 4 | Select turnaround cycles |
| cfg_page_en | input | 1 | Page read mode for the bank |
| req_valid | input | 1 | Read request |
| req_bank | input | 2 | Bank of the request |
| req_addr | input | 16 | Address of the request |
| req_ready | output | 1 | Request accepted at the next edge when high |
| rsp_done | output | 1 | One-cycle pulse with valid rsp_data |
| rsp_data | output | 16 | Captured read data |
| bus_addr | output | 16 | External address bus |
| bus_cs_n | output | 4 | Active-low chip select, one bit per bank |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_data_in | input | 16 | External read data |

## Verification
Two things can land on the same clock edge: a timing write and the acceptance of a read to the same bank. The bench provokes this by driving cfg_we and req_valid in the same cycle with different timing values. The read must run with the old setup, strobe and hold counts, and the following read must use the new ones. A second collision comes from clearing a bank's page enable while its page is open and then requesting the same page. That request must be treated as a miss: the old hold runs first, and it is measured as extra select cycles before the strobe.

// File: rtl/ers_pkg.sv
// Package: shared widths, timing word layout and sequencer state encoding.
// Assumes every count field fits in the widest counter (CNT_W).
package ers_pkg;

    parameter int SETUP_W = 4;
    parameter int STRB_W  = 6;
    parameter int HOLD_W  = 4;

    localparam int CNT_W_A = (SETUP_W > STRB_W) ? SETUP_W : STRB_W;
    localparam int CNT_W   = (HOLD_W > CNT_W_A) ? HOLD_W : CNT_W_A;

    typedef struct packed {
        logic              page_en;
        logic [HOLD_W-1:0]  hold;
        logic [STRB_W-1:0]  strobe;
        logic [SETUP_W-1:0] setup;
    } ers_timing_t;

    localparam ers_timing_t TIMING_RST = '{
        page_en: 1'b0,
        hold:    {HOLD_W{1'b1}},
        strobe:  {STRB_W{1'b1}},
        setup:   {SETUP_W{1'b1}}
    };

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_OPEN   = 3'd4
    } ers_state_e;

endpackage

// File: rtl/ers_cfg_regs.sv
// Module: per-bank timing word register file.
// One word per bank, replaced whole when wr_en names that bank.
// Assumes wr_bank < NUM_BANKS; out-of-range indices write nothing.
module ers_cfg_regs
    import ers_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [BANK_W-1:0]             wr_bank,
    input  ers_timing_t                   wr_val,
    output ers_timing_t [NUM_BANKS-1:0]   cfg_o
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ers_timing_t word_q;

        // Hold the timing word of bank b, loading it on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= TIMING_RST;
            else if (wr_en && (wr_bank == BANK_W'(b)))
                word_q <= wr_val;
        end

        assign cfg_o[b] = word_q;
    end

endmodule

// File: rtl/ers_cycle_cnt.sv
// Module: phase length down-counter.
// A load sets the remaining count (length minus one); last_o flags the final
// cycle of the phase. The count rests at zero when not loaded.
module ers_cycle_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last_o
);

    logic [W-1:0] cnt_q;

    // Load a new phase length or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign last_o = (cnt_q == '0);

endmodule

// File: rtl/ers_fsm.sv
// Module: read cycle control state machine.
// Accepts requests in IDLE or OPEN, snapshots the bank timing word at accept,
// sequences setup/strobe/hold through the shared counter, keeps a page open
// when enabled and parks a missing request while the open page is closed.
// Assumes cnt_last refers to the phase loaded on the previous transition.
module ers_fsm
    import ers_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 16,
    parameter int PAGE_LSB  = 3,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [BANK_W-1:0]           req_bank,
    input  logic [ADDR_W-1:0]           req_addr,
    input  ers_timing_t [NUM_BANKS-1:0] cfg,
    input  logic                        cnt_last,
    output logic                        cnt_load,
    output logic [CNT_W-1:0]            cnt_val,
    output ers_state_e                  state_o,
    output logic [BANK_W-1:0]           cur_bank_o,
    output logic [ADDR_W-1:0]           cur_addr_o,
    output logic                        cap_o,
    output logic                        ready_o
);

    ers_state_e         state_q, state_d;
    ers_timing_t        cur_t_q, pend_t_q, req_t;
    logic [BANK_W-1:0]  cur_bank_q, pend_bank_q;
    logic [ADDR_W-1:0]  cur_addr_q, pend_addr_q;
    logic               pend_valid_q;
    logic               load_cur, load_pend, pend_to_cur, page_hit;

    // Strobe length minus one, with a zero field stretched to one cycle.
    function automatic logic [CNT_W-1:0] strb_cnt(input ers_timing_t t);
        return (t.strobe == '0) ? '0 : CNT_W'(t.strobe) - CNT_W'(1);
    endfunction

    // First phase of a full cycle: setup when non-zero, else the strobe.
    function automatic ers_state_e first_state(input ers_timing_t t);
        return (t.setup != '0) ? ST_SETUP : ST_STROBE;
    endfunction

    // Counter value for the first phase of a full cycle.
    function automatic logic [CNT_W-1:0] first_cnt(input ers_timing_t t);
        return (t.setup != '0) ? CNT_W'(t.setup) - CNT_W'(1) : strb_cnt(t);
    endfunction

    assign req_t    = cfg[req_bank];
    assign ready_o  = (state_q == ST_IDLE) || (state_q == ST_OPEN);
    assign page_hit = (state_q == ST_OPEN) && (req_bank == cur_bank_q) &&
                      (req_addr[ADDR_W-1:PAGE_LSB] == cur_addr_q[ADDR_W-1:PAGE_LSB]) &&
                      req_t.page_en;

    // Choose the next phase and the counter load for it.
    always_comb begin
        state_d     = state_q;
        cnt_load    = 1'b0;
        cnt_val     = '0;
        cap_o       = 1'b0;
        load_cur    = 1'b0;
        load_pend   = 1'b0;
        pend_to_cur = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    load_cur = 1'b1;
                    state_d  = first_state(req_t);
                    cnt_load = 1'b1;
                    cnt_val  = first_cnt(req_t);
                end
            end
            ST_SETUP: begin
                if (cnt_last) begin
                    state_d  = ST_STROBE;
                    cnt_load = 1'b1;
                    cnt_val  = strb_cnt(cur_t_q);
                end
            end
            ST_STROBE: begin
                if (cnt_last) begin
                    cap_o = 1'b1;
                    if (cur_t_q.page_en) begin
                        state_d = ST_OPEN;
                    end else if (cur_t_q.hold != '0) begin
                        state_d  = ST_HOLD;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(cur_t_q.hold) - CNT_W'(1);
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_HOLD: begin
                if (cnt_last) begin
                    if (pend_valid_q) begin
                        pend_to_cur = 1'b1;
                        state_d     = first_state(pend_t_q);
                        cnt_load    = 1'b1;
                        cnt_val     = first_cnt(pend_t_q);
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_OPEN: begin
                if (req_valid) begin
                    if (page_hit) begin
                        load_cur = 1'b1;
                        state_d  = ST_STROBE;
                        cnt_load = 1'b1;
                        cnt_val  = strb_cnt(req_t);
                    end else if (cur_t_q.hold != '0) begin
                        load_pend = 1'b1;
                        state_d   = ST_HOLD;
                        cnt_load  = 1'b1;
                        cnt_val   = CNT_W'(cur_t_q.hold) - CNT_W'(1);
                    end else begin
                        load_cur = 1'b1;
                        state_d  = first_state(req_t);
                        cnt_load = 1'b1;
                        cnt_val  = first_cnt(req_t);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Advance the state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Capture the running read's bank, address and timing snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_t_q    <= TIMING_RST;
            cur_bank_q <= '0;
            cur_addr_q <= '0;
        end else if (load_cur) begin
            cur_t_q    <= req_t;
            cur_bank_q <= req_bank;
            cur_addr_q <= req_addr;
        end else if (pend_to_cur) begin
            cur_t_q    <= pend_t_q;
            cur_bank_q <= pend_bank_q;
            cur_addr_q <= pend_addr_q;
        end
    end

    // Park a page-miss request while the open page is being closed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid_q <= 1'b0;
            pend_t_q     <= TIMING_RST;
            pend_bank_q  <= '0;
            pend_addr_q  <= '0;
        end else if (load_pend) begin
            pend_valid_q <= 1'b1;
            pend_t_q     <= req_t;
            pend_bank_q  <= req_bank;
            pend_addr_q  <= req_addr;
        end else if (pend_to_cur) begin
            pend_valid_q <= 1'b0;
        end
    end

    assign state_o    = state_q;
    assign cur_bank_o = cur_bank_q;
    assign cur_addr_o = cur_addr_q;

endmodule

// File: rtl/ext_rd_seq.sv
// Module: external bus read timing sequencer (top).
// Ties the timing register file, the phase counter and the control machine
// together, decodes the per-bank select and output enable from the state and
// registers read data at the end of the strobe.
// Assumes bus_data_in is valid at the edge that ends the last strobe cycle.
module ext_rd_seq
    import ers_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int PAGE_LSB  = 3,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [BANK_W-1:0]    cfg_bank,
    input  logic [SETUP_W-1:0]   cfg_setup,
    input  logic [STRB_W-1:0]    cfg_strobe,
    input  logic [HOLD_W-1:0]    cfg_hold,
    input  logic                 cfg_page_en,
    input  logic                 req_valid,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 req_ready,
    output logic                 rsp_done,
    output logic [DATA_W-1:0]    rsp_data,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [NUM_BANKS-1:0] bus_cs_n,
    output logic                 bus_oe_n,
    input  logic [DATA_W-1:0]    bus_data_in
);

    ers_timing_t [NUM_BANKS-1:0] cfg;
    ers_timing_t                 wr_val;
    ers_state_e                  state;
    logic [BANK_W-1:0]           cur_bank;
    logic                        cnt_load, cnt_last, cap;
    logic [CNT_W-1:0]            cnt_val;

    assign wr_val = '{page_en: cfg_page_en, hold: cfg_hold,
                      strobe: cfg_strobe, setup: cfg_setup};

    ers_cfg_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_bank (cfg_bank),
        .wr_val  (wr_val),
        .cfg_o   (cfg)
    );

    ers_cycle_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .last_o   (cnt_last)
    );

    ers_fsm #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_bank   (req_bank),
        .req_addr   (req_addr),
        .cfg        (cfg),
        .cnt_last   (cnt_last),
        .cnt_load   (cnt_load),
        .cnt_val    (cnt_val),
        .state_o    (state),
        .cur_bank_o (cur_bank),
        .cur_addr_o (bus_addr),
        .cap_o      (cap),
        .ready_o    (req_ready)
    );

    // One select line per bank, low while that bank owns the bus.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
        assign bus_cs_n[b] = !((state != ST_IDLE) && (cur_bank == BANK_W'(b)));
    end

    assign bus_oe_n = (state != ST_STROBE);

    // Register read data and the done pulse at the end of the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done <= 1'b0;
            rsp_data <= '0;
        end else begin
            rsp_done <= cap;
            if (cap)
                rsp_data <= bus_data_in;
        end
    end

endmodule

// File: rtl/ers_chk.sv
// Module: protocol checker for ext_rd_seq, bound into every instance.
// Assumes it observes the top-level ports only.
module ers_chk #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_ready,
    input logic                 rsp_done,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [NUM_BANKS-1:0] bus_cs_n,
    input logic                 bus_oe_n
);

    a_r6_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n));

    a_r6_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_n |-> ($countones(~bus_cs_n) == 1));

    a_r6_no_ready_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> bus_oe_n);

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r4_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_done) |-> ($past(bus_oe_n) == 1'b0) && bus_oe_n);

    a_r2_addr_stable_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe_n && !$past(bus_oe_n)) |-> $stable(bus_addr));

endmodule

bind ext_rd_seq ers_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .bus_addr  (bus_addr),
    .bus_cs_n  (bus_cs_n),
    .bus_oe_n  (bus_oe_n)
);

// File: tb/ext_rd_seq_tb.sv
// Bench: directed corner cases plus seeded random reads and timing writes,
// each read measured at the pins against a bench timing model.
module ext_rd_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_bank = '0;
    logic [3:0]  cfg_setup = '0;
    logic [5:0]  cfg_strobe = '0;
    logic [3:0]  cfg_hold = '0;
    logic        cfg_page_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [15:0] req_addr = '0;
    logic        req_ready, rsp_done, bus_oe_n;
    logic [15:0] rsp_data, bus_addr, bus_data_in;
    logic [3:0]  bus_cs_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_run = 0;

    // Bench timing model.
    int m_setup[4], m_strobe[4], m_hold[4];
    bit m_pe[4];
    bit open_valid = 0;
    int open_bank = 0;
    int open_hold = 0;
    logic [15:0] open_addr = '0;

    always #10 clk = ~clk;

    ext_rd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
        .cfg_page_en(cfg_page_en), .req_valid(req_valid), .req_bank(req_bank),
        .req_addr(req_addr), .req_ready(req_ready), .rsp_done(rsp_done),
        .rsp_data(rsp_data), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
        .bus_oe_n(bus_oe_n), .bus_data_in(bus_data_in)
    );

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    assign bus_data_in = bus_oe_n ? 16'hDEAD : mem_word(bus_addr);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int b, input int s, input int st,
                             input int h, input bit pe);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = 2'(b); cfg_setup = 4'(s);
        cfg_strobe = 6'(st); cfg_hold = 4'(h); cfg_page_en = pe;
        @(negedge clk);
        cfg_we = 1'b0;
        m_setup[b] = s; m_strobe[b] = st; m_hold[b] = h; m_pe[b] = pe;
    endtask

    // Issue one read and measure setup, strobe, hold and data at the pins.
    task automatic do_read(input int b, input logic [15:0] a, input string tag);
        bit hit;
        int e_setup, e_strb, e_hold;
        int c_setup = 0, c_strb = 0, c_hold = 0, c_done = 0, guard = 0;
        bit seen_oe = 0, after = 0, multi_cs = 0;
        logic [15:0] got = '0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        hit = open_valid && (open_bank == b) && (open_addr[15:3] == a[15:3]) && m_pe[b];
        e_setup = hit ? 0 : m_setup[b];
        if (open_valid && !hit && open_bank == b) e_setup += open_hold;
        e_strb = (m_strobe[b] == 0) ? 1 : m_strobe[b];
        e_hold = m_pe[b] ? 0 : m_hold[b];
        open_valid = m_pe[b]; open_bank = b; open_addr = a; open_hold = m_hold[b];
        req_valid = 1'b1; req_bank = 2'(b); req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (guard < 600) begin
            guard++;
            if ($countones(~bus_cs_n) > 1) multi_cs = 1;
            if (rsp_done) begin c_done++; got = rsp_data; end
            if (!bus_oe_n) begin seen_oe = 1; c_strb++; end
            else if (!seen_oe) begin if (!bus_cs_n[b]) c_setup++; end
            else begin
                after = 1;
                if (req_ready) break;
                if (!bus_cs_n[b]) c_hold++;
            end
            @(negedge clk);
        end
        chk(guard < 600, "R6", {tag, " read returned to ready"}, guard, 600);
        chk(c_setup == e_setup, hit ? "R10" : "R2", {tag, " setup cycles"}, c_setup, e_setup);
        chk(c_strb == e_strb, "R3", {tag, " strobe cycles"}, c_strb, e_strb);
        chk(c_hold == e_hold, m_pe[b] ? "R9" : "R5", {tag, " hold cycles"}, c_hold, e_hold);
        chk(c_done == 1 && got == mem_word(a), "R4", {tag, " data"}, int'(got), int'(mem_word(a)));
        chk(!multi_cs, "R6", {tag, " single select"}, int'(multi_cs), 0);
        if (!m_pe[b])
            chk(bus_cs_n == 4'hF, "R5", {tag, " idle selects"}, int'(bus_cs_n), 15);
        else
            chk(!bus_cs_n[b] && bus_oe_n, "R9", {tag, " page left open"}, int'(bus_cs_n[b]), 0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_setup[i] = 15; m_strobe[i] = 63; m_hold[i] = 15; m_pe[i] = 0;
        end
        void'($urandom(32'h1F2E3D));
        repeat (3) @(negedge clk);
        // R1: reset state at the pins.
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(bus_cs_n == 4'hF, "R1", "selects after reset", int'(bus_cs_n), 15);
        chk(bus_oe_n == 1'b1, "R1", "oe after reset", int'(bus_oe_n), 1);
        chk(rsp_done == 1'b0, "R1", "done after reset", int'(rsp_done), 0);
        rst_n = 1'b1;
        // R1: default timing 15/63/15 on bank 0 and bank 3.
        do_read(0, 16'h1234, "R1 default b0");
        do_read(3, 16'h0F0F, "R1 default b3");

        // R7: independent per-bank timing; bank 1 all-zero covers R3 stretch.
        cfg_write(0, 2, 3, 1, 0);
        cfg_write(1, 0, 0, 0, 0);
        cfg_write(2, 3, 5, 2, 1);
        cfg_write(3, 1, 2, 4, 0);
        do_read(0, 16'h0040, "R7 b0");
        do_read(1, 16'h8001, "R3 zero strobe b1");
        do_read(3, 16'h4444, "R7 b3");

        // R9/R10/R11: page open, hit, miss in same bank, miss to other bank.
        do_read(2, 16'h0100, "R9 open b2");
        do_read(2, 16'h0105, "R10 hit b2");
        do_read(2, 16'h0200, "R11 miss same bank");
        do_read(0, 16'h0041, "R11 miss other bank");

        // R8: write during a running read leaves it alone.
        fork
            do_read(3, 16'h3030, "R8 mid-cycle write");
            begin repeat (2) @(negedge clk); cfg_write(3, 5, 7, 3, 0); end
        join
        do_read(3, 16'h3031, "R8 new timing b3");

        // R8: write at the accepting edge of the same bank.
        fork
            do_read(0, 16'h0A0A, "R8 same-edge write");
            cfg_write(0, 4, 4, 4, 0);
        join
        do_read(0, 16'h0A0B, "R8 new timing b0");

        // R10/R11: page enable cleared while page open turns a same-page request into a miss.
        do_read(2, 16'h0600, "R9 reopen b2");
        cfg_write(2, 1, 2, 3, 0);
        do_read(2, 16'h0601, "R11 page disabled while open");

        // Seeded random mix of timing writes and reads.
        for (int it = 0; it < 60; it++) begin
            int b;
            logic [15:0] a;
            b = int'($urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0)
                cfg_write(b, int'($urandom_range(0, 7)), int'($urandom_range(0, 9)),
                          int'($urandom_range(0, 5)), bit'($urandom_range(0, 1)));
            if (open_valid && $urandom_range(0, 1) == 1)
                a = {open_addr[15:3], 3'($urandom_range(0, 7))};
            else
                a = 16'($urandom);
            if (open_valid && $urandom_range(0, 2) == 0) b = open_bank;
            do_read(b, a, "R7 random");
        end

        done_run = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_run) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R6 watchdog expired: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule